// File: doc/BRIEF.md
# Branch Target Buffer with Per-Direction Way-Pointer Sets

This block is a direct-mapped branch target buffer for an instruction fetch unit that saves cache energy. Each entry holds a branch tag and a target address. It also holds two sets of cache way pointers, one for the taken path and one for the not-taken path, and each set has its own valid flag. A lookup is made only for instructions that pre-decode has marked as branches or jumps. It returns the hit, the target, and the pointer set that matches the supplied direction prediction. A mode controller outside the block can then open only the recorded data ways instead of running tag checks.

The mode controller marks a lookup to be remembered, and the block keeps that lookup in a saved-branch register. Later the controller sends a recorded pointer set, and the block writes it into the saved entry and direction. When the instruction cache misses, the controller asks for a bulk invalidation of every pointer-set valid flag. A pointer write and a bulk invalidation each use the single array port for one cycle. During that cycle the block raises a stall, and any lookup or allocation offered in that cycle is ignored.

The control states are IDLE (the port serves lookups and allocations), WRITE (the port stores a recorded set) and FLUSH (the port clears every pointer flag). The transitions are named GO_FLUSH (a flush request, which wins over a write), GO_WRITE (a write request with no flush) and RETURN (no request, back to IDLE). They are evaluated from every state, so requests that arrive back to back each take one stall cycle.

Top module: `wpb_btb`

## Requirements
- R1: After reset, stall_o, lk_vld_o and repl_o are 0, and every entry is empty, so any lookup misses.
- R2: A lookup offered with lk_req=1 in a cycle with stall_o=0 gives lk_vld_o=1 in the next cycle. lk_hit_o=1 only when the indexed entry is valid and its tag matches, and lk_target_o then gives the stored target. A cycle with lk_req=0 gives lk_vld_o=0 in the next cycle.
- R3: The entry index is pc[IDX_W+1:2] and the tag is pc[PC_W-1:IDX_W+2], where IDX_W=log2(ENTRIES). Two addresses with the same index and different tags alias to one entry and do not both hit.
- R4: An allocation accepted with alloc_req=1 and stall_o=0 writes the tag and target and clears both pointer-set valid flags of that entry. In the next cycle repl_o=1 exactly when the entry was valid before with a different tag.
- R5: On a hit, lk_wp_vld_o and lk_wps_o come from the taken set when pred_taken=1 and from the not-taken set otherwise. Pointer i sits at bits [i*WAY_W +: WAY_W].
- R6: rec_req=1 captures rec_wps. The next cycle is a stall cycle. At the end of it, the captured set is stored into the saved entry and direction, and that set's valid flag is set.
- R7: An accepted lookup with lk_save=1 loads the saved-branch register with the index, the tag and pred_taken.
- R8: A pointer write has no effect when the saved register is empty, or when the saved entry is no longer valid with the saved tag.
- R9: flush_req=1 causes one stall cycle. At the end of it, every pointer-set valid flag is cleared and the saved register is emptied. Tags and targets are kept.
- R10: In a stall cycle, lk_req and alloc_req are ignored. lk_vld_o is 0 in the next cycle and no entry is written.
- R11: When flush_req and rec_req come in the same cycle, the flush wins and the write is dropped. A request made in a stall cycle adds one more stall cycle, and the last write captured is the one that remains.
- R12: A lookup and an allocation to the same index in the same cycle: the lookup returns the contents from before the allocation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_req | input | 1 | Lookup request (pre-decoded branch or jump) |
| lk_save | input | 1 | Load the saved-branch register with this lookup |
| lk_pc | input | PC_W | Fetch address of the lookup |
| pred_taken | input | 1 | Predicted direction (1 = taken) |
| lk_vld_o | output | 1 | Lookup result valid |
| lk_hit_o | output | 1 | Entry matched |
| lk_target_o | output | PC_W | Stored target address |
| lk_wp_vld_o | output | 1 | Selected pointer set is valid |
| lk_wps_o | output | NUM_WP*WAY_W | Selected pointer set |
| alloc_req | input | 1 | Allocate an entry |
| alloc_pc | input | PC_W | Branch address to allocate |
| alloc_target | input | PC_W | Target to store |
| repl_o | output | 1 | The allocation displaced a different valid branch |
| rec_req | input | 1 | Write the recorded pointer set |
| rec_wps | input | NUM_WP*WAY_W | Recorded pointer set |
| flush_req | input | 1 | Invalidate all pointer sets (cache miss) |
| stall_o | output | 1 | Array port busy; lookups and allocations are ignored |

## Verification
The bench builds the block with ENTRIES=8 and keeps NUM_WP=4 and WAYS=4. With these values an alias is only 32 bytes away from its partner, so replacement, stale saved-register writes and index aliasing can all be reached with a few hand-picked addresses. The 8-bit pointer sets with distinct patterns per direction show directly whether the taken or the not-taken set was returned and whether the pointers are packed in the right order.

// File: rtl/wpb_pkg.sv
package wpb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_FLUSH = 2'd2
    } wpb_state_e;

endpackage

// File: rtl/wpb_fsm.sv
module wpb_fsm
    import wpb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flush_req,
    input  logic rec_req,
    output logic stall_o,
    output logic do_write_o,
    output logic do_flush_o
);

    wpb_state_e state_q, state_d;

    // next-state: GO_FLUSH beats GO_WRITE, otherwise RETURN
    always_comb begin
        if (flush_req)      state_d = ST_FLUSH;
        else if (rec_req)   state_d = ST_WRITE;
        else                state_d = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        stall_o    = 1'b0;
        do_write_o = 1'b0;
        do_flush_o = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_WRITE: begin
                stall_o    = 1'b1;
                do_write_o = 1'b1;
            end
            ST_FLUSH: begin
                stall_o    = 1'b1;
                do_flush_o = 1'b1;
            end
            default:  stall_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/wpb_hold.sv
module wpb_hold #(
    parameter int IDX_W = 4,
    parameter int TAG_W = 26,
    parameter int SET_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic [IDX_W-1:0] cap_idx,
    input  logic [TAG_W-1:0] cap_tag,
    input  logic             cap_dir,
    input  logic             rec_req,
    input  logic [SET_W-1:0] rec_wps,
    input  logic             clr,
    output logic             sv_valid_o,
    output logic [IDX_W-1:0] sv_idx_o,
    output logic [TAG_W-1:0] sv_tag_o,
    output logic             sv_dir_o,
    output logic [SET_W-1:0] rec_q_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sv_valid_o <= 1'b0;
            sv_idx_o   <= '0;
            sv_tag_o   <= '0;
            sv_dir_o   <= 1'b0;
        end else if (clr) begin
            sv_valid_o <= 1'b0;
        end else if (cap_en) begin
            sv_valid_o <= 1'b1;
            sv_idx_o   <= cap_idx;
            sv_tag_o   <= cap_tag;
            sv_dir_o   <= cap_dir;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rec_q_o <= '0;
        else if (rec_req) rec_q_o <= rec_wps;
    end

endmodule

// File: rtl/wpb_array.sv
module wpb_array #(
    parameter int ENTRIES = 16,
    parameter int PC_W    = 32,
    parameter int IDX_W   = 4,
    parameter int TAG_W   = 26,
    parameter int SET_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    input  logic             rd_dir,
    output logic             rd_hit_o,
    output logic [PC_W-1:0]  rd_target_o,
    output logic             rd_wpv_o,
    output logic [SET_W-1:0] rd_wps_o,
    input  logic             alloc_en,
    input  logic [IDX_W-1:0] alloc_idx,
    input  logic [TAG_W-1:0] alloc_tag,
    input  logic [PC_W-1:0]  alloc_target,
    output logic             alloc_repl_o,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             wr_dir,
    input  logic [SET_W-1:0] wr_set,
    input  logic             flush_en
);

    logic [ENTRIES-1:0] v_vec, wvt_vec, wvn_vec;
    logic [TAG_W-1:0]   tag_arr [ENTRIES];
    logic [PC_W-1:0]    tgt_arr [ENTRIES];
    logic [SET_W-1:0]   st_arr  [ENTRIES];
    logic [SET_W-1:0]   sn_arr  [ENTRIES];
    logic               wr_match;

    assign wr_match = wr_en && v_vec[wr_idx] && (tag_arr[wr_idx] == wr_tag);

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        logic             ev, evt, evn;
        logic [TAG_W-1:0] et;
        logic [PC_W-1:0]  eg;
        logic [SET_W-1:0] est, esn;
        logic             sel_a, sel_w;

        assign sel_a = alloc_en && (alloc_idx == IDX_W'(e));
        assign sel_w = wr_match && (wr_idx == IDX_W'(e));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ev  <= 1'b0;
                evt <= 1'b0;
                evn <= 1'b0;
                et  <= '0;
                eg  <= '0;
                est <= '0;
                esn <= '0;
            end else if (flush_en) begin
                evt <= 1'b0;
                evn <= 1'b0;
            end else if (sel_a) begin
                ev  <= 1'b1;
                et  <= alloc_tag;
                eg  <= alloc_target;
                evt <= 1'b0;
                evn <= 1'b0;
            end else if (sel_w) begin
                if (wr_dir) begin
                    est <= wr_set;
                    evt <= 1'b1;
                end else begin
                    esn <= wr_set;
                    evn <= 1'b1;
                end
            end
        end

        assign v_vec[e]   = ev;
        assign wvt_vec[e] = evt;
        assign wvn_vec[e] = evn;
        assign tag_arr[e] = et;
        assign tgt_arr[e] = eg;
        assign st_arr[e]  = est;
        assign sn_arr[e]  = esn;
    end

    assign rd_hit_o     = v_vec[rd_idx] && (tag_arr[rd_idx] == rd_tag);
    assign rd_target_o  = tgt_arr[rd_idx];
    assign rd_wpv_o     = rd_hit_o && (rd_dir ? wvt_vec[rd_idx] : wvn_vec[rd_idx]);
    assign rd_wps_o     = rd_dir ? st_arr[rd_idx] : sn_arr[rd_idx];
    assign alloc_repl_o = v_vec[alloc_idx] && (tag_arr[alloc_idx] != alloc_tag);

endmodule

// File: rtl/wpb_btb.sv
module wpb_btb #(
    parameter int ENTRIES = 16,
    parameter int PC_W    = 32,
    parameter int NUM_WP  = 4,
    parameter int WAYS    = 4,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int TAG_W  = PC_W - IDX_W - 2,
    localparam int WAY_W  = $clog2(WAYS),
    localparam int SET_W  = NUM_WP * WAY_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_req,
    input  logic             lk_save,
    input  logic [PC_W-1:0]  lk_pc,
    input  logic             pred_taken,
    output logic             lk_vld_o,
    output logic             lk_hit_o,
    output logic [PC_W-1:0]  lk_target_o,
    output logic             lk_wp_vld_o,
    output logic [SET_W-1:0] lk_wps_o,
    input  logic             alloc_req,
    input  logic [PC_W-1:0]  alloc_pc,
    input  logic [PC_W-1:0]  alloc_target,
    output logic             repl_o,
    input  logic             rec_req,
    input  logic [SET_W-1:0] rec_wps,
    input  logic             flush_req,
    output logic             stall_o
);

    logic             do_write, do_flush;
    logic             lk_acc, al_acc;
    logic [IDX_W-1:0] lk_idx, al_idx, sv_idx;
    logic [TAG_W-1:0] lk_tag, al_tag, sv_tag;
    logic             sv_valid, sv_dir;
    logic [SET_W-1:0] rec_q;
    logic             rd_hit, rd_wpv, al_repl;
    logic [PC_W-1:0]  rd_target;
    logic [SET_W-1:0] rd_wps;
    logic             unused_lsb;

    assign unused_lsb = ^{lk_pc[1:0], alloc_pc[1:0]};

    assign lk_idx = lk_pc[IDX_W+1:2];
    assign lk_tag = lk_pc[PC_W-1:IDX_W+2];
    assign al_idx = alloc_pc[IDX_W+1:2];
    assign al_tag = alloc_pc[PC_W-1:IDX_W+2];
    assign lk_acc = lk_req && !stall_o;
    assign al_acc = alloc_req && !stall_o;

    wpb_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_req  (flush_req),
        .rec_req    (rec_req),
        .stall_o    (stall_o),
        .do_write_o (do_write),
        .do_flush_o (do_flush)
    );

    wpb_hold #(.IDX_W(IDX_W), .TAG_W(TAG_W), .SET_W(SET_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_en     (lk_acc && lk_save),
        .cap_idx    (lk_idx),
        .cap_tag    (lk_tag),
        .cap_dir    (pred_taken),
        .rec_req    (rec_req),
        .rec_wps    (rec_wps),
        .clr        (do_flush),
        .sv_valid_o (sv_valid),
        .sv_idx_o   (sv_idx),
        .sv_tag_o   (sv_tag),
        .sv_dir_o   (sv_dir),
        .rec_q_o    (rec_q)
    );

    wpb_array #(
        .ENTRIES(ENTRIES), .PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .SET_W(SET_W)
    ) u_arr (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_idx       (lk_idx),
        .rd_tag       (lk_tag),
        .rd_dir       (pred_taken),
        .rd_hit_o     (rd_hit),
        .rd_target_o  (rd_target),
        .rd_wpv_o     (rd_wpv),
        .rd_wps_o     (rd_wps),
        .alloc_en     (al_acc),
        .alloc_idx    (al_idx),
        .alloc_tag    (al_tag),
        .alloc_target (alloc_target),
        .alloc_repl_o (al_repl),
        .wr_en        (do_write && sv_valid),
        .wr_idx       (sv_idx),
        .wr_tag       (sv_tag),
        .wr_dir       (sv_dir),
        .wr_set       (rec_q),
        .flush_en     (do_flush)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_vld_o    <= 1'b0;
            lk_hit_o    <= 1'b0;
            lk_target_o <= '0;
            lk_wp_vld_o <= 1'b0;
            lk_wps_o    <= '0;
            repl_o      <= 1'b0;
        end else begin
            lk_vld_o    <= lk_acc;
            lk_hit_o    <= lk_acc && rd_hit;
            lk_target_o <= rd_target;
            lk_wp_vld_o <= lk_acc && rd_wpv;
            lk_wps_o    <= rd_wps;
            repl_o      <= al_acc && al_repl;
        end
    end

endmodule

// File: rtl/wpb_btb_chk.sv
module wpb_btb_chk (
    input logic clk,
    input logic rst_n,
    input logic lk_req,
    input logic alloc_req,
    input logic rec_req,
    input logic flush_req,
    input logic stall_o,
    input logic lk_vld_o,
    input logic lk_hit_o,
    input logic lk_wp_vld_o,
    input logic repl_o
);

    p_lookup_answers_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && !stall_o) |=> lk_vld_o);

    p_hit_needs_vld_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit_o |-> lk_vld_o);

    p_repl_needs_alloc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(alloc_req && !stall_o) |=> !repl_o);

    p_wpv_needs_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lk_wp_vld_o |-> lk_hit_o);

    p_write_stalls_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rec_req |=> stall_o);

    p_flush_stalls_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |=> stall_o);

    p_no_result_after_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |=> !lk_vld_o);

    p_stall_needs_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_req && !rec_req) |=> !stall_o);

endmodule

bind wpb_btb wpb_btb_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_req      (lk_req),
    .alloc_req   (alloc_req),
    .rec_req     (rec_req),
    .flush_req   (flush_req),
    .stall_o     (stall_o),
    .lk_vld_o    (lk_vld_o),
    .lk_hit_o    (lk_hit_o),
    .lk_wp_vld_o (lk_wp_vld_o),
    .repl_o      (repl_o)
);

// File: tb/wpb_btb_test.sv
module wpb_btb_test;

    localparam logic [2:0] NOP = 3'd0, LOOK = 3'd1, ALLOC = 3'd2, REC = 3'd3, FLUSH = 3'd4;

    typedef struct packed {
        logic [2:0]  op;
        logic [31:0] pc;
        logic [31:0] dat;
        logic        dir;
        logic        sv;
        logic        e_hit;
        logic        e_wpv;
        logic [31:0] e_tgt;
        logic [7:0]  e_wps;
        logic        e_repl;
        logic [3:0]  req;
    } vec_t;

    // A=0x1004 idx1, A2=0x1024 idx1 other tag, B=0x1008 idx2 (ENTRIES=8)
    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        '{LOOK,  32'h1004, 32'h0,    1'b1, 1'b0, 1'b0, 1'b0, 32'h0,    8'h00, 1'b0, 4'd2},  // R2 miss
        '{ALLOC, 32'h1004, 32'h2000, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,    8'h00, 1'b0, 4'd4},  // R4
        '{LOOK,  32'h1004, 32'h0,    1'b1, 1'b1, 1'b1, 1'b0, 32'h2000, 8'h00, 1'b0, 4'd7},  // R7
        '{REC,   32'h0,    32'hE4,   1'b0, 1'b0, 1'b0, 1'b0, 32'h0,    8'h00, 1'b0, 4'd6},  // R6
        '{LOOK,  32'h1004, 32'h0,    1'b1, 1'b0, 1'b1, 1'b1, 32'h2000, 8'hE4, 1'b0, 4'd5},  // R5
        '{LOOK,  32'h1004, 32'h0,    1'b0, 1'b0, 1'b1, 1'b0, 32'h2000, 8'h00, 1'b0, 4'd5},  // R5
        '{LOOK,  32'h1004, 32'h0,    1'b0, 1'b1, 1'b1, 1'b0, 32'h2000, 8'h00, 1'b0, 4'd7},  // R7
        '{REC,   32'h0,    32'h1B,   1'b0, 1'b0, 1'b0, 1'b0, 32'h0,    8'h00, 1'b0, 4'd6},  // R6
        '{LOOK,  32'h1004, 32'h0,    1'b0, 1'b0, 1'b1, 1'b1, 32'h2000, 8'h1B, 1'b0, 4'd5},  // R5
        '{LOOK,  32'h1004, 32'h0,    1'b1, 1'b0, 1'b1, 1'b1, 32'h2000, 8'hE4, 1'b0, 4'd5},  // R5
        '{ALLOC, 32'h1008, 32'h3000, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,    8'h00, 1'b0, 4'd4},  // R4
        '{LOOK,  32'h1008, 32'h0,    1'b1, 1'b1, 1'b1, 1'b0, 32'h3000, 8'h00, 1'b0, 4'd7},  // R7
        '{ALLOC, 32'h1024, 32'h4000, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,    8'h00, 1'b1, 4'd4},  // R4 repl
        '{LOOK,  32'h1004, 32'h0,    1'b1, 1'b0, 1'b0, 1'b0, 32'h0,    8'h00, 1'b0, 4'd3},  // R3 alias
        '{LOOK,  32'h1024, 32'h0,    1'b1, 1'b0, 1'b1, 1'b0, 32'h4000, 8'h00, 1'b0, 4'd4},  // R4 cleared
        '{REC,   32'h0,    32'hFF,   1'b0, 1'b0, 1'b0, 1'b0, 32'h0,    8'h00, 1'b0, 4'd6},  // R6 into B
        '{LOOK,  32'h1008, 32'h0,    1'b1, 1'b0, 1'b1, 1'b1, 32'h3000, 8'hFF, 1'b0, 4'd6},  // R6
        '{FLUSH, 32'h0,    32'h0,    1'b0, 1'b0, 1'b0, 1'b0, 32'h0,    8'h00, 1'b0, 4'd9},  // R9
        '{LOOK,  32'h1008, 32'h0,    1'b1, 1'b0, 1'b1, 1'b0, 32'h3000, 8'h00, 1'b0, 4'd9},  // R9 tag kept
        '{REC,   32'h0,    32'h55,   1'b0, 1'b0, 1'b0, 1'b0, 32'h0,    8'h00, 1'b0, 4'd8},  // R8 empty saved
        '{LOOK,  32'h1008, 32'h0,    1'b1, 1'b0, 1'b1, 1'b0, 32'h3000, 8'h00, 1'b0, 4'd8},  // R8
        '{LOOK,  32'h1024, 32'h0,    1'b1, 1'b1, 1'b1, 1'b0, 32'h4000, 8'h00, 1'b0, 4'd7},  // R7
        '{ALLOC, 32'h1004, 32'h5000, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,    8'h00, 1'b1, 4'd4},  // R4 repl
        '{REC,   32'h0,    32'hAA,   1'b0, 1'b0, 1'b0, 1'b0, 32'h0,    8'h00, 1'b0, 4'd8},  // R8 stale
        '{LOOK,  32'h1004, 32'h0,    1'b1, 1'b0, 1'b1, 1'b0, 32'h5000, 8'h00, 1'b0, 4'd8},  // R8
        '{NOP,   32'h0,    32'h0,    1'b0, 1'b0, 1'b0, 1'b0, 32'h0,    8'h00, 1'b0, 4'd2}   // R2 idle
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0, lk_save = 1'b0, pred_taken = 1'b0;
    logic [31:0] lk_pc = '0;
    logic        lk_vld_o, lk_hit_o, lk_wp_vld_o, repl_o, stall_o;
    logic [31:0] lk_target_o;
    logic [7:0]  lk_wps_o;
    logic        alloc_req = 1'b0;
    logic [31:0] alloc_pc = '0, alloc_target = '0;
    logic        rec_req = 1'b0, flush_req = 1'b0;
    logic [7:0]  rec_wps = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wpb_btb #(.ENTRIES(8)) uut (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_save(lk_save), .lk_pc(lk_pc),
        .pred_taken(pred_taken), .lk_vld_o(lk_vld_o), .lk_hit_o(lk_hit_o),
        .lk_target_o(lk_target_o), .lk_wp_vld_o(lk_wp_vld_o), .lk_wps_o(lk_wps_o),
        .alloc_req(alloc_req), .alloc_pc(alloc_pc), .alloc_target(alloc_target),
        .repl_o(repl_o), .rec_req(rec_req), .rec_wps(rec_wps), .flush_req(flush_req),
        .stall_o(stall_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic quiet();
        lk_req = 1'b0; lk_save = 1'b0; alloc_req = 1'b0; rec_req = 1'b0; flush_req = 1'b0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic lookup(input logic [31:0] pc, input logic dir, input logic sv);
        lk_req = 1'b1; lk_pc = pc; pred_taken = dir; lk_save = sv;
        step();
        quiet();
    endtask

    task automatic check_look(input string tag, input logic h, input logic w,
                              input logic [31:0] t, input logic [7:0] p);
        check({tag, " vld"}, 32'(lk_vld_o), 32'd1);
        check({tag, " hit"}, 32'(lk_hit_o), 32'(h));
        if (h) check({tag, " target"}, lk_target_o, t);
        check({tag, " wpv"}, 32'(lk_wp_vld_o), 32'(w));
        if (w) check({tag, " wps"}, 32'(lk_wps_o), 32'(p));
    endtask

    task automatic run_vec(input vec_t v);
        string tag;
        tag = $sformatf("R%0d", v.req);
        case (v.op)
            LOOK: begin
                lookup(v.pc, v.dir, v.sv);
                check_look(tag, v.e_hit, v.e_wpv, v.e_tgt, v.e_wps);
            end
            ALLOC: begin
                alloc_req = 1'b1; alloc_pc = v.pc; alloc_target = v.dat;
                step(); quiet();
                check({tag, " repl"}, 32'(repl_o), 32'(v.e_repl));
            end
            REC, FLUSH: begin
                if (v.op == REC) begin rec_req = 1'b1; rec_wps = v.dat[7:0]; end
                else flush_req = 1'b1;
                step(); quiet();
                check({tag, " stall"}, 32'(stall_o), 32'd1);
                step();
                check({tag, " stall end"}, 32'(stall_o), 32'd0);
            end
            default: begin
                step();
                check({tag, " no lookup"}, 32'(lk_vld_o), 32'd0);
            end
        endcase
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 stall", 32'(stall_o), 32'd0);
        check("R1 vld", 32'(lk_vld_o), 32'd0);
        check("R1 repl", 32'(repl_o), 32'd0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R10: lookup and allocation of C (0x100C) offered in a stall cycle are dropped
        flush_req = 1'b1;
        step(); quiet();
        check("R10 stall", 32'(stall_o), 32'd1);
        lk_req = 1'b1; lk_pc = 32'h100C; pred_taken = 1'b1;
        alloc_req = 1'b1; alloc_pc = 32'h100C; alloc_target = 32'h6000;
        step(); quiet();
        check("R10 no result", 32'(lk_vld_o), 32'd0);
        check("R10 no repl", 32'(repl_o), 32'd0);
        lookup(32'h100C, 1'b1, 1'b0);
        check_look("R10 not allocated", 1'b0, 1'b0, 32'h0, 8'h0);

        // R12: same-cycle lookup and allocation of C
        lk_req = 1'b1; lk_pc = 32'h100C; pred_taken = 1'b1;
        alloc_req = 1'b1; alloc_pc = 32'h100C; alloc_target = 32'h6000;
        step(); quiet();
        check_look("R12 old contents", 1'b0, 1'b0, 32'h0, 8'h0);
        lookup(32'h100C, 1'b1, 1'b0);
        check_look("R12 new contents", 1'b1, 1'b0, 32'h6000, 8'h0);

        // R11: back-to-back writes, the later one remains
        lookup(32'h1008, 1'b1, 1'b1);
        rec_req = 1'b1; rec_wps = 8'h12;
        step();
        rec_wps = 8'h34;
        check("R11 stall 1", 32'(stall_o), 32'd1);
        step(); quiet();
        check("R11 stall 2", 32'(stall_o), 32'd1);
        step();
        check("R11 stall end", 32'(stall_o), 32'd0);
        lookup(32'h1008, 1'b1, 1'b0);
        check_look("R11 last write", 1'b1, 1'b1, 32'h3000, 8'h34);

        // R11: flush and write together, flush wins
        lookup(32'h1008, 1'b1, 1'b1);
        flush_req = 1'b1; rec_req = 1'b1; rec_wps = 8'h77;
        step(); quiet();
        check("R11 one stall", 32'(stall_o), 32'd1);
        step();
        check("R11 stall over", 32'(stall_o), 32'd0);
        lookup(32'h1008, 1'b1, 1'b0);
        check_look("R11 flush won", 1'b1, 1'b0, 32'h3000, 8'h0);

        // R1: reset again empties the table
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        step();
        check("R1 stall again", 32'(stall_o), 32'd0);
        lookup(32'h1008, 1'b1, 1'b0);
        check_look("R1 empty", 1'b0, 1'b0, 32'h0, 8'h0);

        finish_run();
    end

endmodule